// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable behavioural model of a small synchronous static RAM. It can take a new read or write on every clock and needs no idle cycle when the data bus turns around. The address, the controls and the byte-lane enables are registered on the rising edge of the address phase. The data transfer for that access takes place in the next clock cycle. Read data is not registered: it flows from the array to a tri-state data bus while the data phase is under way. Write data is taken from the bus on the edge that closes the data phase.

An active-low clock enable freezes the whole pipeline. Three chip selects gate new accesses. A single direction line picks read or write, and an asynchronous output enable can release the bus at any moment. An advance/load input either starts a new access at the external address or steps a four-beat burst, in linear or interleaved order. The default array is 256 words by 36 bits, split into four 9-bit lanes.

Top module: `zbt_ft_sram`

## Requirements
- R1: When `adv_ld` is 0, `cen_n` is 0 and the chip is selected, the access is sampled on that edge. The transfer takes place during the following cycle. A read drives word `addr` onto `dq` combinationally during that cycle.
- R2: Writes and reads may alternate on consecutive edges with no idle cycle. A read issued on the edge right after a write to the same address returns the newly written data.
- R3: While `cen_n` is 1, every synchronous input is ignored. The pending transfer, its address and the read data on `dq` stay as they are, and no array write takes place on that edge.
- R4: The chip is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A load (`adv_ld`=0) with any select inactive starts nothing and ends any burst, but a transfer already pending still completes.
- R5: `dq` is released (high impedance) in the cycle after a deselect, and in the data cycle of a write.
- R6: `oe_n`=1 releases `dq` at once, without waiting for a clock edge, even while a read is pending.
- R7: Lane i covers `dq[9i+8:9i]`. On a write, only lanes with `bw_n[i]`=0 are stored, and the other lanes keep their contents.
- R8: With `linear`=1, burst beat n (n = 0 to 3) uses the loaded address with its two low bits replaced by (low bits + n) mod 4.
- R9: With `linear`=0, burst beat n uses the loaded address with its two low bits XOR n.
- R10: `adv_ld`=1 continues an active burst in the direction of the load that opened it, taking a fresh `bw_n` each beat and wrapping after four beats. With no burst active, `adv_ld`=1 is a no-operation.
- R11: After reset, no transfer is pending and `dq` is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| cen_n | input | 1 | Active-low clock enable; high suspends the block |
| ce1_n | input | 1 | Active-low chip select |
| ce2 | input | 1 | Active-high chip select |
| ce3_n | input | 1 | Active-low chip select |
| adv_ld | input | 1 | 0 loads a new access, 1 advances the burst |
| rw | input | 1 | Direction of a loaded access: 1 read, 0 write |
| bw_n | input | LANES | Active-low per-lane write enables |
| linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | ADDR_W | Word address |
| dq | inout | LANES*LANE_W | Bidirectional data bus |

## Verification
The bench uses the default parameters: an 8-bit address, four 9-bit lanes and a 2-bit burst counter. With these, every word can be written in a 256-cycle fill before any read. After that, each random read has a known expected value, and random addresses land on recent writes often. The 2-bit counter makes the burst wrap after the fourth beat, so a five-beat burst covers both orders in a few cycles. A pull-up on the bus shows high impedance as all ones.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    typedef enum logic [1:0] {
        XFER_NONE  = 2'd0,
        XFER_READ  = 2'd1,
        XFER_WRITE = 2'd2
    } xfer_e;
endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq #(
    parameter int BURST_W = 2
) (
    input  logic [BURST_W-1:0] base_lo,
    input  logic [BURST_W-1:0] step,
    input  logic               linear,
    output logic [BURST_W-1:0] offset
);
    logic [BURST_W-1:0] lin_off;
    logic [BURST_W-1:0] ilv_off;

    assign lin_off = base_lo + step;
    assign ilv_off = base_lo ^ step;
    assign offset  = linear ? lin_off : ilv_off;
endmodule

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n,
    input  logic              adv_ld,
    input  logic              sel,
    input  logic              rw,
    input  logic [LANES-1:0]  bw_n,
    input  logic              linear,
    input  logic [ADDR_W-1:0] addr,
    output xfer_e             xfer,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LANES-1:0]  xfer_lanes,
    output logic              burst_live
);
    localparam int HI_W = ADDR_W - BURST_W;

    typedef struct packed {
        xfer_e              xfer;
        logic [ADDR_W-1:0]  addr;
        logic [LANES-1:0]   lanes;
        logic               live;
        logic               wr;
        logic [HI_W-1:0]    base_hi;
        logic [BURST_W-1:0] base_lo;
        logic [BURST_W-1:0] cnt;
    } ctrl_st_t;

    ctrl_st_t           st_d, st_q;
    logic [BURST_W-1:0] cnt_next_d;
    logic [BURST_W-1:0] beat_off_d;

    assign cnt_next_d = st_q.cnt + 1'b1;

    zbt_burst_seq #(.BURST_W(BURST_W)) u_seq (
        .base_lo (st_q.base_lo),
        .step    (cnt_next_d),
        .linear  (linear),
        .offset  (beat_off_d)
    );

    always_comb begin
        st_d = st_q;
        if (!cen_n) begin
            if (!adv_ld) begin
                if (sel) begin
                    st_d.xfer    = rw ? XFER_READ : XFER_WRITE;
                    st_d.addr    = addr;
                    st_d.lanes   = ~bw_n;
                    st_d.live    = 1'b1;
                    st_d.wr      = ~rw;
                    st_d.base_hi = addr[ADDR_W-1:BURST_W];
                    st_d.base_lo = addr[BURST_W-1:0];
                    st_d.cnt     = '0;
                end else begin
                    st_d.xfer = XFER_NONE;
                    st_d.live = 1'b0;
                end
            end else if (st_q.live) begin
                st_d.xfer  = st_q.wr ? XFER_WRITE : XFER_READ;
                st_d.addr  = {st_q.base_hi, beat_off_d};
                st_d.lanes = ~bw_n;
                st_d.cnt   = cnt_next_d;
            end else begin
                st_d.xfer = XFER_NONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign xfer       = st_q.xfer;
    assign xfer_addr  = st_q.addr;
    assign xfer_lanes = st_q.lanes;
    assign burst_live = st_q.live;
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[g]) begin
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[addr];
    end
endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cen_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    adv_ld,
    input  logic                    rw,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    linear,
    input  logic                    oe_n,
    input  logic [ADDR_W-1:0]       addr,
    inout  wire  [LANES*LANE_W-1:0] dq
);
    localparam int DATA_W = LANES * LANE_W;

    xfer_e             xfer;
    logic [ADDR_W-1:0] pend_addr;
    logic [LANES-1:0]  pend_lanes;
    logic              burst_live;
    logic              sel;
    logic              pend_valid;
    logic              pend_rd;
    logic              arr_we;
    logic [DATA_W-1:0] arr_rdata;

    assign sel = !ce1_n && ce2 && !ce3_n;

    zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cen_n      (cen_n),
        .adv_ld     (adv_ld),
        .sel        (sel),
        .rw         (rw),
        .bw_n       (bw_n),
        .linear     (linear),
        .addr       (addr),
        .xfer       (xfer),
        .xfer_addr  (pend_addr),
        .xfer_lanes (pend_lanes),
        .burst_live (burst_live)
    );

    assign pend_valid = (xfer != XFER_NONE);
    assign pend_rd    = (xfer == XFER_READ);
    assign arr_we     = !cen_n && (xfer == XFER_WRITE);

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .we      (arr_we),
        .lane_en (pend_lanes),
        .addr    (pend_addr),
        .wdata   (dq),
        .rdata   (arr_rdata)
    );

    assign dq = (pend_rd && !oe_n) ? arr_rdata : {DATA_W{1'bz}};
endmodule

// File: rtl/zbt_ft_sram_chk.sv
module zbt_ft_sram_chk #(
    parameter int ADDR_W  = 8,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cen_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              adv_ld,
    input logic              rw,
    input logic [ADDR_W-1:0] addr,
    input logic              pend_valid,
    input logic              pend_rd,
    input logic [ADDR_W-1:0] pend_addr,
    input logic              burst_live
);
    logic chosen;
    assign chosen = !ce1_n && ce2 && !ce3_n;

    AST_LOAD_READ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && chosen && rw) |=> (pend_rd && pend_addr == $past(addr))); // R1

    AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> ($stable(pend_addr) && $stable(pend_valid) && $stable(pend_rd))); // R3

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && !chosen) |=> (!pend_valid && !burst_live)); // R4

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && chosen && !rw) |=> !pend_rd); // R5

    AST_BURST_SAME_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld && burst_live) |=>
        (pend_valid && pend_addr[ADDR_W-1:BURST_W] == $past(pend_addr[ADDR_W-1:BURST_W]))); // R8

    AST_ADVANCE_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld && !burst_live) |=> !pend_valid); // R10
endmodule

bind zbt_ft_sram zbt_ft_sram_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cen_n      (cen_n),
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .adv_ld     (adv_ld),
    .rw         (rw),
    .addr       (addr),
    .pend_valid (pend_valid),
    .pend_rd    (pend_rd),
    .pend_addr  (pend_addr),
    .burst_live (burst_live)
);

// File: tb/sim_zbt_ft_sram.sv
`timescale 1ns/1ps
module sim_zbt_ft_sram;
    localparam int AW = 8;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;
    localparam logic [2:0] SEL = 3'b010;  // {ce1_n, ce2, ce3_n}

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cen_n = 1'b1, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic adv_ld = 1'b0, rw = 1'b1, linear = 1'b1, oe_n = 1'b0;
    logic [NL-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] tb_dq = '0;
    logic tb_drv = 1'b0;
    tri1 [DW-1:0] dq;

    assign dq = tb_drv ? tb_dq : {DW{1'bz}};

    always #2 clk = ~clk;

    zbt_ft_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .BURST_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adv_ld(adv_ld), .rw(rw), .bw_n(bw_n), .linear(linear),
        .oe_n(oe_n), .addr(addr), .dq(dq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model
    logic [DW-1:0] refm [1 << AW];
    logic          m_v = 1'b0, m_w = 1'b0, m_live = 1'b0, m_dir = 1'b0;
    logic [AW-1:0] m_a = '0, m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic [NL-1:0] m_ln = '0;
    logic [DW-1:0] m_wd = '0;

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b,
                                                input logic [1:0] n, input logic lin);
        logic [1:0] lo;
        lo = lin ? (b[1:0] + n) : (b[1:0] ^ n);
        return {b[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] expect_bus();
        if (m_v && !m_w && !oe_n) return refm[m_a];
        return {DW{1'b1}};
    endfunction

    task automatic check_bus(input string tag);
        logic [DW-1:0] e;
        if (tb_drv) return;
        e = expect_bus();
        n_chk++;
        if (dq !== e) begin
            n_fail++;
            $display("FAIL %s: dq actual %h expected %h (pending v=%0b w=%0b a=%h oe_n=%0b)",
                     tag, dq, e, m_v, m_w, m_a, oe_n);
        end
    endtask

    task automatic cyc(input logic c_cen, input logic c_adv, input logic c_rw,
                       input logic [2:0] c_ce, input logic [NL-1:0] c_bw,
                       input logic c_lin, input logic [AW-1:0] c_a,
                       input logic c_oe, input logic nodrv, input string tag);
        logic [63:0] r64;
        logic [1:0]  nc;
        @(negedge clk);
        check_bus(tag);
        r64 = {$urandom(), $urandom()};
        tb_drv = m_v && m_w && !nodrv;
        tb_dq  = r64[DW-1:0];
        m_wd   = tb_drv ? tb_dq : {DW{1'b1}};
        cen_n = c_cen; adv_ld = c_adv; rw = c_rw;
        {ce1_n, ce2, ce3_n} = c_ce;
        bw_n = c_bw; linear = c_lin; addr = c_a; oe_n = c_oe;
        #1;
        check_bus(tag);
        @(posedge clk);
        if (!c_cen) begin
            if (m_v && m_w) begin
                for (int l = 0; l < NL; l++)
                    if (m_ln[l]) refm[m_a][l*LW +: LW] = m_wd[l*LW +: LW];
            end
            if (!c_adv) begin
                if (c_ce == SEL) begin
                    m_v = 1'b1; m_w = !c_rw; m_dir = !c_rw; m_a = c_a;
                    m_base = c_a; m_cnt = '0; m_live = 1'b1; m_ln = ~c_bw;
                end else begin
                    m_v = 1'b0; m_live = 1'b0;
                end
            end else if (m_live) begin
                nc = m_cnt + 2'd1;
                m_cnt = nc;
                m_a = beat_addr(m_base, nc, c_lin);
                m_v = 1'b1; m_w = m_dir; m_ln = ~c_bw;
            end else begin
                m_v = 1'b0;
            end
        end
    endtask

    task automatic ld_wr(input logic [AW-1:0] a, input logic [NL-1:0] b, input string tag);
        cyc(1'b0, 1'b0, 1'b0, SEL, b, 1'b1, a, 1'b0, 1'b0, tag);
    endtask
    task automatic ld_rd(input logic [AW-1:0] a, input string tag);
        cyc(1'b0, 1'b0, 1'b1, SEL, 4'hf, 1'b1, a, 1'b0, 1'b0, tag);
    endtask
    task automatic nop(input string tag);
        cyc(1'b0, 1'b0, 1'b1, 3'b110, 4'hf, 1'b1, '0, 1'b0, 1'b0, tag);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: nothing pending after reset, bus released
        nop("R11");
        nop("R11");

        // R1: fill every word, then read some back
        for (int i = 0; i < (1 << AW); i++) ld_wr(AW'(i), 4'h0, "R1");
        nop("R1");
        for (int i = 0; i < 8; i++) ld_rd(AW'(i * 29), "R1");
        nop("R1");

        // R2: alternating write/read, read-after-write same address
        ld_wr(8'h10, 4'h0, "R2");
        ld_rd(8'h10, "R2");
        ld_wr(8'h11, 4'h0, "R2");
        ld_rd(8'h10, "R2");
        ld_rd(8'h11, "R2");
        ld_wr(8'h12, 4'h0, "R2");
        ld_rd(8'h12, "R2");
        nop("R2");

        // R7: partial lane write (lanes 0 and 2)
        ld_wr(8'h20, 4'b1010, "R7");
        ld_rd(8'h20, "R7");
        ld_wr(8'h21, 4'b0111, "R7");
        ld_rd(8'h21, "R7");
        nop("R7");

        // R3: suspension holds read data, ignores a write attempt
        ld_rd(8'h30, "R3");
        for (int k = 0; k < 3; k++)
            cyc(1'b1, 1'b0, 1'b0, SEL, 4'h0, 1'b1, 8'h30, 1'b0, 1'b0, "R3");
        nop("R3");
        ld_rd(8'h30, "R3");
        ld_wr(8'h31, 4'h0, "R3");
        cyc(1'b1, 1'b0, 1'b1, SEL, 4'hf, 1'b1, 8'h00, 1'b0, 1'b0, "R3");
        cyc(1'b1, 1'b0, 1'b1, SEL, 4'hf, 1'b1, 8'h00, 1'b0, 1'b0, "R3");
        nop("R3");
        ld_rd(8'h31, "R3");
        nop("R3");

        // R4: each select inactive blocks a write; pending read completes
        ld_rd(8'h40, "R4");
        cyc(1'b0, 1'b0, 1'b0, 3'b110, 4'h0, 1'b1, 8'h40, 1'b0, 1'b0, "R4");
        cyc(1'b0, 1'b0, 1'b0, 3'b000, 4'h0, 1'b1, 8'h40, 1'b0, 1'b0, "R4");
        cyc(1'b0, 1'b0, 1'b0, 3'b011, 4'h0, 1'b1, 8'h40, 1'b0, 1'b0, "R4");
        ld_rd(8'h40, "R4");
        nop("R4");

        // R5: bus released during a write data cycle (bench not driving)
        ld_rd(8'h50, "R5");
        ld_wr(8'h50, 4'h0, "R5");
        cyc(1'b0, 1'b0, 1'b1, 3'b110, 4'hf, 1'b1, 8'h00, 1'b0, 1'b1, "R5");
        ld_rd(8'h50, "R5");
        nop("R5");

        // R6: asynchronous output enable
        ld_rd(8'h60, "R6");
        cyc(1'b0, 1'b0, 1'b1, SEL, 4'hf, 1'b1, 8'h61, 1'b1, 1'b0, "R6");
        cyc(1'b0, 1'b0, 1'b1, 3'b110, 4'hf, 1'b1, 8'h00, 1'b0, 1'b0, "R6");
        nop("R6");

        // R8: linear burst from 0x76 with wrap
        cyc(1'b0, 1'b0, 1'b1, SEL, 4'hf, 1'b1, 8'h76, 1'b0, 1'b0, "R8");
        for (int k = 0; k < 4; k++)
            cyc(1'b0, 1'b1, 1'b0, 3'b111, 4'h0, 1'b1, 8'h00, 1'b0, 1'b0, "R8");
        nop("R8");

        // R9: interleaved burst from 0x76
        cyc(1'b0, 1'b0, 1'b1, SEL, 4'hf, 1'b0, 8'h76, 1'b0, 1'b0, "R9");
        for (int k = 0; k < 4; k++)
            cyc(1'b0, 1'b1, 1'b0, 3'b111, 4'h0, 1'b0, 8'h00, 1'b0, 1'b0, "R9");
        nop("R9");

        // R10: write burst inherits direction, then read it back; advance with no burst
        cyc(1'b0, 1'b0, 1'b0, SEL, 4'h0, 1'b1, 8'h85, 1'b0, 1'b0, "R10");
        cyc(1'b0, 1'b1, 1'b1, SEL, 4'h0, 1'b1, 8'h00, 1'b0, 1'b0, "R10");
        cyc(1'b0, 1'b1, 1'b1, SEL, 4'b1100, 1'b1, 8'h00, 1'b0, 1'b0, "R10");
        cyc(1'b0, 1'b1, 1'b1, SEL, 4'h0, 1'b1, 8'h00, 1'b0, 1'b0, "R10");
        cyc(1'b0, 1'b0, 1'b1, SEL, 4'hf, 1'b1, 8'h85, 1'b0, 1'b0, "R10");
        for (int k = 0; k < 4; k++)
            cyc(1'b0, 1'b1, 1'b0, 3'b000, 4'h0, 1'b1, 8'h00, 1'b0, 1'b0, "R10");
        nop("R10");
        cyc(1'b0, 1'b1, 1'b0, SEL, 4'h0, 1'b1, 8'h33, 1'b0, 1'b0, "R10");
        cyc(1'b0, 1'b1, 1'b1, SEL, 4'h0, 1'b1, 8'h33, 1'b0, 1'b0, "R10");
        nop("R10");
        ld_rd(8'h33, "R10");
        nop("R10");

        // random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [2:0] ce;
            logic [31:0] r;
            r = $urandom();
            case (r[6:4])
                3'd0:    ce = 3'b110;
                3'd1:    ce = 3'b000;
                3'd2:    ce = 3'b011;
                default: ce = SEL;
            endcase
            cyc((r[3:0] == 4'd0), (r[9:8] == 2'd0), r[10], ce, r[14:11],
                r[15], r[23:16], (r[27:24] == 4'd0), 1'b0, "R1");
        end
        nop("R1");
        nop("R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule